// File: doc/BRIEF.md
# Decaying Volume Envelope Generator

This block produces the 4-bit volume of a tone channel. It advances only on a quarter-frame strobe, which comes from a frame sequencer outside the block. A control byte sets three things: whether the envelope repeats, whether the output is a fixed volume, and a 4-bit value N. N is the fixed volume when that mode is selected, and otherwise the period of the decay divider. The decay level starts at 15 and falls one step every N+1 strobes. At zero it either stops there or jumps back to 15.

A restart strobe marks the envelope for reinitialisation. The owning channel raises this strobe when its length/high-period register is written. The restart does not act at once; it acts on the next quarter-frame strobe. For debug, the decay level and the divider are brought out as ports.

Top module: `envgen_top`

## Requirements
- R1: While `rst` is high (synchronous, active high), the volume, decay level, divider, pending start flag, repeat flag, fixed-volume flag and N are all cleared to zero.
- R2: A cycle with `ctrl_we` high loads the repeat flag from `ctrl_byte` bit 5, the fixed-volume flag from bit 4 and N from bits 3..0; bits 7..6 are ignored. The new values are visible from the next cycle. The write changes neither the divider nor the decay level.
- R3: `restart` sets a pending start flag and by itself changes neither the level nor the divider. The next `qclk` consumes the flag: it sets the level to 15, loads the divider with N and clears the flag.
- R4: On a `qclk` with no pending start, a nonzero divider counts down by one. A zero divider reloads with N and makes one decay step, so a decay step happens every N+1 strobes.
- R5: A decay step lowers a nonzero level by one.
- R6: A decay step at level 0 sets the level to 15 when the repeat flag is 1, and otherwise leaves it at 0.
- R7: With the fixed-volume flag set, `vol_out` equals N. With it clear, `vol_out` equals the decay level. The level and the divider keep advancing in both modes.
- R8: The level and the divider change only in cycles where `qclk` or `rst` is high.
- R9: When `restart` and `qclk` are high in the same cycle, the strobe acts on the start flag as it was before that cycle. The flag is then left pending for the following strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write enable |
| ctrl_byte | input | 8 | Control byte: bit 5 repeat, bit 4 fixed volume, bits 3..0 N |
| restart | input | 1 | Restart request strobe |
| qclk | input | 1 | Quarter-frame clock enable strobe |
| vol_out | output | 4 | Registered volume output |
| dbg_level | output | 4 | Current decay level |
| dbg_div | output | 4 | Current divider count |

## Verification
The first pattern is N=0 with no repeat. It runs the whole fall from 15 to 0 and shows the level holding at zero, which separates R5 from R6. A second pattern uses N=3 with repeat and leaves idle gaps between strobes. It separates the divider cadence from the strobe timing and exercises the wrap to 15. Fixed-volume runs show the output pinned to N while the debug level keeps decaying. A restart that lands on a strobe, and a control write with the upper bits set, cover the ordering and masking cases. A long pseudo-random mix of writes, restarts and strobes is compared against a model built from the requirements.

// File: rtl/envgen_pkg.sv
package envgen_pkg;
  localparam int ENV_W = 4;

  typedef enum logic [1:0] {
    DIV_IDLE  = 2'd0,
    DIV_START = 2'd1,
    DIV_COUNT = 2'd2,
    DIV_STEP  = 2'd3
  } div_act_e;
endpackage

// File: rtl/envgen_cfg_reg.sv
module envgen_cfg_reg #(
  parameter int CTRL_W    = 8,
  parameter int VAL_W     = 4,
  parameter int LOOP_BIT  = 5,
  parameter int CONST_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] ctrl_byte,
  output logic              loop_q,
  output logic              const_q,
  output logic [VAL_W-1:0]  n_q,
  output logic              const_d,
  output logic [VAL_W-1:0]  n_d
);
  logic loop_d;
  logic unused_ctrl_bits;

  assign unused_ctrl_bits = ^ctrl_byte[CTRL_W-1:CONST_BIT+1];

  always_comb begin
    loop_d  = loop_q;
    const_d = const_q;
    n_d     = n_q;
    if (we) begin
      loop_d  = ctrl_byte[LOOP_BIT];
      const_d = ctrl_byte[CONST_BIT];
      n_d     = ctrl_byte[VAL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loop_q  <= 1'b0;
      const_q <= 1'b0;
      n_q     <= '0;
    end else begin
      loop_q  <= loop_d;
      const_q <= const_d;
      n_q     <= n_d;
    end
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    we |=> (n_q == $past(ctrl_byte[VAL_W-1:0])) && (loop_q == $past(ctrl_byte[LOOP_BIT]))); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(n_q) && $stable(const_q) && $stable(loop_q)); // R2
endmodule

// File: rtl/envgen_start_flag.sv
module envgen_start_flag (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic qclk,
  output logic start_q
);
  logic start_d;

  always_comb begin
    start_d = start_q;
    if (qclk)    start_d = 1'b0;
    if (restart) start_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= start_d;
  end

  AST_RESTART_PENDS: assert property (@(posedge clk) disable iff (rst)
    restart |=> start_q); // R9
  AST_START_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    (qclk && !restart) |=> !start_q); // R3
endmodule

// File: rtl/envgen_divider.sv
module envgen_divider
  import envgen_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         qclk,
  input  logic         start,
  input  logic [W-1:0] reload,
  output logic [W-1:0] div_q,
  output logic         step
);
  div_act_e     act;
  logic [W-1:0] div_d;

  always_comb begin
    if (!qclk)            act = DIV_IDLE;
    else if (start)       act = DIV_START;
    else if (div_q != '0) act = DIV_COUNT;
    else                  act = DIV_STEP;
  end

  always_comb begin
    unique case (act)
      DIV_START, DIV_STEP: div_d = reload;
      DIV_COUNT:           div_d = div_q - 1'b1;
      default:             div_d = div_q;
    endcase
  end

  assign step = (act == DIV_STEP);

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_d;
  end

  AST_DIV_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    (qclk && start) |=> div_q == $past(reload)); // R3
  AST_DIV_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (qclk && !start && div_q != '0) |=> div_q == $past(div_q) - 1'b1); // R4
  AST_DIV_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !qclk |=> $stable(div_q)); // R8
endmodule

// File: rtl/envgen_decay.sv
module envgen_decay #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         qclk,
  input  logic         start,
  input  logic         step,
  input  logic         loop_en,
  output logic [W-1:0] level_d,
  output logic [W-1:0] level_q
);
  localparam logic [W-1:0] LVL_MAX = {W{1'b1}};

  always_comb begin
    level_d = level_q;
    if (qclk && start)          level_d = LVL_MAX;
    else if (step) begin
      if (level_q != '0)        level_d = level_q - 1'b1;
      else if (loop_en)         level_d = LVL_MAX;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_d;
  end

  AST_LVL_START_MAX: assert property (@(posedge clk) disable iff (rst)
    (qclk && start) |=> level_q == LVL_MAX); // R3
  AST_LVL_FLOOR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step && level_q == '0 && !loop_en) |=> level_q == '0); // R6
  AST_LVL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && level_q == '0 && loop_en) |=> level_q == LVL_MAX); // R6
  AST_LVL_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !qclk |=> $stable(level_q)); // R8
endmodule

// File: rtl/envgen_top.sv
module envgen_top
  import envgen_pkg::*;
#(
  parameter int CTRL_W    = 8,
  parameter int LVL_W     = ENV_W,
  parameter int LOOP_BIT  = 5,
  parameter int CONST_BIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_byte,
  input  logic              restart,
  input  logic              qclk,
  output logic [LVL_W-1:0]  vol_out,
  output logic [LVL_W-1:0]  dbg_level,
  output logic [LVL_W-1:0]  dbg_div
);
  logic             loop_q, const_q, const_d, start_q, step;
  logic [LVL_W-1:0] n_q, n_d, level_d, level_q, div_q;
  logic [LVL_W-1:0] vol_q;

  envgen_cfg_reg #(
    .CTRL_W(CTRL_W), .VAL_W(LVL_W), .LOOP_BIT(LOOP_BIT), .CONST_BIT(CONST_BIT)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(ctrl_we), .ctrl_byte(ctrl_byte),
    .loop_q(loop_q), .const_q(const_q), .n_q(n_q),
    .const_d(const_d), .n_d(n_d)
  );

  envgen_start_flag u_start (
    .clk(clk), .rst(rst), .restart(restart), .qclk(qclk), .start_q(start_q)
  );

  envgen_divider #(.W(LVL_W)) u_div (
    .clk(clk), .rst(rst), .qclk(qclk), .start(start_q), .reload(n_q),
    .div_q(div_q), .step(step)
  );

  envgen_decay #(.W(LVL_W)) u_decay (
    .clk(clk), .rst(rst), .qclk(qclk), .start(start_q), .step(step),
    .loop_en(loop_q), .level_d(level_d), .level_q(level_q)
  );

  always_ff @(posedge clk) begin
    if (rst) vol_q <= '0;
    else     vol_q <= const_d ? n_d : level_d;
  end

  assign vol_out   = vol_q;
  assign dbg_level = level_q;
  assign dbg_div   = div_q;

  AST_FIXED_VOL: assert property (@(posedge clk) disable iff (rst)
    const_q |-> vol_out == n_q); // R7
  AST_DECAY_VOL: assert property (@(posedge clk) disable iff (rst)
    !const_q |-> vol_out == level_q); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (vol_out == '0) && (level_q == '0) && (div_q == '0) && !start_q); // R1
endmodule

// File: tb/envgen_top_test.sv
module envgen_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_byte = 8'h00;
  logic       restart = 1'b0;
  logic       qclk = 1'b0;
  logic [3:0] vol_out, dbg_level, dbg_div;

  always #4 clk = ~clk;

  envgen_top uut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_byte(ctrl_byte),
    .restart(restart), .qclk(qclk),
    .vol_out(vol_out), .dbg_level(dbg_level), .dbg_div(dbg_div)
  );

  typedef struct {
    logic [3:0] vol;
    logic [3:0] lvl;
    logic [3:0] dv;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  bit         m_loop, m_const, m_start;
  logic [3:0] m_n, m_lvl, m_div;

  task automatic drive(input bit r, input bit we, input logic [7:0] b,
                       input bit rs, input bit qc, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; ctrl_we = we; ctrl_byte = b; restart = rs; qclk = qc;
    if (r) begin
      m_loop = 0; m_const = 0; m_start = 0; m_n = 0; m_lvl = 0; m_div = 0;
    end else begin
      if (qc) begin
        if (m_start) begin
          m_lvl = 4'd15; m_div = m_n; m_start = 0;
        end else if (m_div != 4'd0) begin
          m_div = m_div - 4'd1;
        end else begin
          m_div = m_n;
          if (m_lvl != 4'd0) m_lvl = m_lvl - 4'd1;
          else if (m_loop)   m_lvl = 4'd15;
        end
      end
      if (rs) m_start = 1;
      if (we) begin m_loop = b[5]; m_const = b[4]; m_n = b[3:0]; end
    end
    e.vol = m_const ? m_n : m_lvl;
    e.lvl = m_lvl;
    e.dv  = m_div;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic strobes(input int n, input int gap, input string tag);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 8'h00, 0, 1, tag);
      for (int g = 0; g < gap; g++) drive(0, 0, 8'h00, 0, 0, "R8");
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done && sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      n_cmp++;
      if (vol_out !== e.vol || dbg_level !== e.lvl || dbg_div !== e.dv) begin
        n_bad++;
        $display("FAIL %s: vol/level/div actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 e.tag, vol_out, dbg_level, dbg_div, e.vol, e.lvl, e.dv);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    // R1: reset state
    drive(1, 0, 8'h00, 0, 0, "R1");
    drive(1, 0, 8'h00, 0, 0, "R1");
    // R2: control write, no repeat, N=0
    drive(0, 1, 8'h00, 0, 0, "R2");
    // R3: restart alone changes nothing until a strobe
    drive(0, 0, 8'h00, 1, 0, "R3");
    drive(0, 0, 8'h00, 0, 0, "R3");
    drive(0, 0, 8'h00, 0, 1, "R3");
    // R5: fall from 15 to 0, then R6 hold at zero
    strobes(15, 0, "R5");
    strobes(3, 0, "R6");
    // R2: write repeat with N=3; level and divider untouched
    drive(0, 1, 8'h23, 0, 0, "R2");
    drive(0, 0, 8'h00, 1, 0, "R3");
    drive(0, 0, 8'h00, 0, 1, "R3");
    // R4 cadence with idle gaps, long enough to wrap (R6)
    strobes(70, 2, "R4");
    strobes(10, 0, "R6");
    // R7: fixed volume with repeat, N=5; decay keeps moving
    drive(0, 1, 8'h35, 0, 0, "R7");
    strobes(20, 1, "R7");
    // R7: fixed volume N=2, no repeat
    drive(0, 1, 8'h12, 1, 0, "R7");
    strobes(12, 0, "R7");
    // R9: restart on the same cycle as a strobe
    drive(0, 1, 8'h01, 0, 0, "R2");
    strobes(3, 0, "R4");
    drive(0, 0, 8'h00, 1, 1, "R9");
    drive(0, 0, 8'h00, 0, 0, "R9");
    drive(0, 0, 8'h00, 0, 1, "R9");
    strobes(4, 0, "R9");
    // R2: upper bits ignored -> N=15, no repeat, no fixed volume
    drive(0, 1, 8'hCF, 0, 0, "R2");
    drive(0, 0, 8'h00, 1, 1, "R2");
    strobes(40, 0, "R4");
    // R1: reset mid-run
    drive(1, 0, 8'h00, 0, 1, "R1");
    drive(0, 0, 8'h00, 0, 0, "R1");
    // pseudo-random mix
    lfsr = 32'h1D2C3B4A;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(0, lfsr[3:0] == 4'd0, lfsr[15:8], lfsr[7:4] == 4'd1,
            lfsr[18:17] != 2'd0, "R4");
    end
    drive(0, 0, 8'h00, 0, 0, "R8");
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule